// File: doc/BRIEF.md
# Drift-Hit Time Binner with Guard Window

This block turns the discriminated pulses of the twelve sense wires of one drift cell into a per-crossing occupancy map. A crossing-start strobe opens a measurement window. The block then samples every wire once per fine tick, which is one clock cycle. Each sample is credited to the time bin that the current tick offset falls in. Bin edges are programmable tick counts, so the bins need not be uniform and can be placed to spread occupancy evenly. When the last bin closes, the block emits the collected flags as one registered map word with a single-cycle valid pulse.

A typical pulse lasts longer than one bin, so most hits mark two neighbouring bins. To keep late pulse tails from being read as new hits, a guard rule applies: during the first few ticks of a bin, a wire that already marked the previous bin cannot mark the new one. A pulse that is still present after the guard interval marks the new bin as usual. A two-bin prompt/delayed mode is kept for older consumers. In that mode only the first two edges are used, the guard rule is off, and the map is packed into the low 24 bits.

Top module: `drift_hit_binner`

## Requirements
- R1: During and after synchronous reset, `map_valid` is 0 and `map_out` is all zeros until a crossing completes.
- R2: In six-bin mode, bin k covers tick offsets from `cfg_edges[8k-1:8k-8]` (0 for k=0) up to but not including `cfg_edges[8k+7:8k]`. Tick offset 0 is the first cycle after the edge that samples `xing_start`. A sampled hit on wire w in bin k sets `map_out` bit 6*w+k.
- R3: A hit that is held across a bin boundary and is still present at a tick outside the guard interval sets both bins.
- R4: In six-bin mode, a hit at a tick offset within `cfg_guard` ticks of the start of bin k (k at least 1) is ignored if the same wire already set bin k-1. The same hit counts normally if bin k-1 of that wire is clear.
- R5: With `legacy_mode`=1, two bins are used: prompt (offsets below edge 0) and delayed (edge 0 up to edge 1). Wire w sets bit 2*w (prompt) or 2*w+1 (delayed). Bits 71:24 are zero, and no guard suppression applies.
- R6: The mode is captured when `xing_start` is sampled. Changing `legacy_mode` during a crossing has no effect on that crossing.
- R7: `map_valid` is high for exactly one cycle, the cycle right after the edge that samples the last tick of the last bin (offset edge[last]-1), and `map_out` holds the frame then.
- R8: A strobe during an open crossing discards all flags collected so far and restarts the tick offset at 0.
- R9: Wire activity while no crossing is open has no effect, and no `map_valid` is produced without a strobe.
- R10: A strobe sampled on the last tick of a crossing still emits that crossing's map and starts a new crossing at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine tick clock |
| rst | input | 1 | Synchronous active-high reset |
| xing_start | input | 1 | Crossing-start strobe |
| legacy_mode | input | 1 | 1 selects two-bin prompt/delayed mode |
| cfg_edges | input | 48 | Six bin end offsets in ticks, 8 bits each, edge k at bits 8k+7:8k |
| cfg_guard | input | 8 | Guard interval length in ticks |
| wire_hit | input | 12 | Discriminator level per wire |
| map_out | output | 72 | Occupancy map of the finished crossing |
| map_valid | output | 1 | One-cycle frame valid |

## Verification
The crossing strobe and the closing tick of the previous crossing can land on the same clock edge. When that happens, the frame must be emitted from flags that include the final sample, while the flag store is cleared for the next crossing. The bench provokes this by raising the strobe on the final tick. It then checks that the first map carries a hit from early in the old window, and that the next map, one full window later, holds only the hit driven after the strobe. The guard rule and the boundary crossing rule also meet in the same tick when a pulse ends exactly at the end of the guard interval. A pair of pulses, one ending on the last guard tick and one lasting one tick longer, tells the two rules apart.

// File: rtl/hbin_pkg.sv
package hbin_pkg;
  typedef enum logic {MODE_SIX = 1'b0, MODE_TWO = 1'b1} bin_mode_e;
  localparam int LEGACY_BINS = 2;
endpackage

// File: rtl/hbin_locator.sv
module hbin_locator #(
  parameter int N_BINS = 6,
  parameter int TW     = 8,
  parameter int IW     = $clog2(N_BINS + 1)
) (
  input  logic [TW-1:0]        cnt,
  input  logic [N_BINS*TW-1:0] edges,
  input  logic [TW-1:0]        guard,
  input  logic                 two_bin,
  output logic [IW-1:0]        bin_idx,
  output logic                 in_window,
  output logic                 in_guard,
  output logic                 last_tick
);
  import hbin_pkg::*;

  logic [IW-1:0] nb;
  logic [TW-1:0] start_t;
  logic [TW-1:0] end_t;

  always_comb begin
    nb = two_bin ? IW'(LEGACY_BINS) : IW'(N_BINS);
    bin_idx = '0;
    for (int k = 0; k < N_BINS; k++) begin
      if (IW'(k) < nb && cnt >= edges[k*TW +: TW]) bin_idx = bin_idx + 1'b1;
    end
    start_t = '0;
    end_t   = '0;
    for (int k = 0; k < N_BINS; k++) begin
      if (bin_idx == IW'(k + 1)) start_t = edges[k*TW +: TW];
      if (nb == IW'(k + 1))      end_t   = edges[k*TW +: TW];
    end
    in_window = bin_idx < nb;
    in_guard  = !two_bin && (bin_idx != '0) &&
                ({1'b0, cnt} < ({1'b0, start_t} + {1'b0, guard}));
    last_tick = cnt == end_t - 1'b1;
  end
endmodule

// File: rtl/hbin_wire_cell.sv
module hbin_wire_cell #(
  parameter int N_BINS = 6,
  parameter int IW     = $clog2(N_BINS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              sample,
  input  logic [IW-1:0]     bin_idx,
  input  logic              in_guard,
  input  logic              hit,
  output logic [N_BINS-1:0] flags_next
);
  logic [N_BINS-1:0] flags_q;
  logic              prev_set;

  always_comb begin
    flags_next = flags_q;
    prev_set   = 1'b0;
    for (int k = 1; k < N_BINS; k++) begin
      if (bin_idx == IW'(k)) prev_set = flags_q[k-1];
    end
    for (int k = 0; k < N_BINS; k++) begin
      if (sample && hit && bin_idx == IW'(k) && !(in_guard && prev_set))
        flags_next[k] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) flags_q <= '0;
    else              flags_q <= flags_next;
  end
endmodule

// File: rtl/drift_hit_binner.sv
module drift_hit_binner #(
  parameter int N_WIRES = 12,
  parameter int N_BINS  = 6,
  parameter int TW      = 8,
  localparam int IW     = $clog2(N_BINS + 1),
  localparam int MAP_W  = N_WIRES * N_BINS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 xing_start,
  input  logic                 legacy_mode,
  input  logic [N_BINS*TW-1:0] cfg_edges,
  input  logic [TW-1:0]        cfg_guard,
  input  logic [N_WIRES-1:0]   wire_hit,
  output logic [MAP_W-1:0]     map_out,
  output logic                 map_valid
);
  import hbin_pkg::*;

  logic [TW-1:0] cnt_q;
  logic          active_q;
  bin_mode_e     mode_q;
  logic [IW-1:0] bin_idx;
  logic          in_window, in_guard, last_tick, sample;
  logic [N_BINS-1:0] fl_next [N_WIRES];
  logic [MAP_W-1:0]  packed_map;

  hbin_locator #(.N_BINS(N_BINS), .TW(TW), .IW(IW)) u_loc (
    .cnt(cnt_q), .edges(cfg_edges), .guard(cfg_guard),
    .two_bin(mode_q == MODE_TWO), .bin_idx(bin_idx),
    .in_window(in_window), .in_guard(in_guard), .last_tick(last_tick)
  );

  assign sample = active_q && in_window;

  for (genvar w = 0; w < N_WIRES; w++) begin : g_wire
    hbin_wire_cell #(.N_BINS(N_BINS), .IW(IW)) u_cell (
      .clk(clk), .rst(rst), .clear(xing_start), .sample(sample),
      .bin_idx(bin_idx), .in_guard(in_guard), .hit(wire_hit[w]),
      .flags_next(fl_next[w])
    );
  end

  always_comb begin
    packed_map = '0;
    for (int w = 0; w < N_WIRES; w++) begin
      if (mode_q == MODE_TWO) begin
        for (int k = 0; k < LEGACY_BINS; k++)
          packed_map[LEGACY_BINS*w + k] = fl_next[w][k];
      end else begin
        for (int k = 0; k < N_BINS; k++)
          packed_map[N_BINS*w + k] = fl_next[w][k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      active_q  <= 1'b0;
      mode_q    <= MODE_SIX;
      map_out   <= '0;
      map_valid <= 1'b0;
    end else begin
      map_valid <= 1'b0;
      if (active_q && last_tick) begin
        map_out   <= packed_map;
        map_valid <= 1'b1;
        active_q  <= 1'b0;
      end
      if (xing_start) begin
        cnt_q    <= '0;
        active_q <= 1'b1;
        mode_q   <= legacy_mode ? MODE_TWO : MODE_SIX;
      end else if (active_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/drift_hit_binner_chk.sv
module drift_hit_binner_chk #(
  parameter int TW    = 8,
  parameter int MAP_W = 72
) (
  input logic             clk,
  input logic             rst,
  input logic             xing_start,
  input logic             active_q,
  input logic             mode_q,
  input logic [TW-1:0]    cnt_q,
  input logic [MAP_W-1:0] map_out,
  input logic             map_valid
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!map_valid && map_out == '0));

  p_tick_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (active_q && !xing_start) |=> (map_valid || cnt_q == TW'($past(cnt_q) + 1)));

  p_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (map_valid && $past(mode_q)) |-> (map_out[MAP_W-1:24] == '0));

  p_valid_from_open_r7: assert property (@(posedge clk) disable iff (rst)
    map_valid |-> $past(active_q));

  p_strobe_restart_r8: assert property (@(posedge clk) disable iff (rst)
    xing_start |=> (active_q && cnt_q == '0));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !xing_start) |=> !map_valid);
endmodule

bind drift_hit_binner drift_hit_binner_chk #(.TW(TW), .MAP_W(MAP_W)) u_chk (
  .clk(clk), .rst(rst), .xing_start(xing_start), .active_q(active_q),
  .mode_q(mode_q), .cnt_q(cnt_q), .map_out(map_out), .map_valid(map_valid)
);

// File: tb/test_drift_hit_binner.sv
module test_drift_hit_binner;
  localparam int CLK_PERIOD = 10;
  localparam int L6 = 148;
  localparam int L2 = 46;

  typedef struct packed {
    logic        two;
    logic [3:0]  w;
    logic [7:0]  s;
    logic [7:0]  len;
    logic [71:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd0,  8'd2,   8'd10, 72'h1},                  // R2 single bin
    '{1'b0, 4'd3,  8'd10,  8'd40, 72'hC0000},              // R4 guard over two boundaries
    '{1'b0, 4'd5,  8'd24,  8'd4,  72'h80000000},           // R4 guard but prev clear
    '{1'b0, 4'd11, 8'd125, 8'd30, 72'h800000000000000000}, // R2 last bin, top wire
    '{1'b0, 4'd7,  8'd90,  8'd40, 72'hE00000000000},       // R3 spans three bins
    '{1'b1, 4'd2,  8'd15,  8'd20, 72'h30},                 // R5 prompt+delayed
    '{1'b1, 4'd9,  8'd30,  8'd5,  72'h80000},              // R5 delayed only
    '{1'b0, 4'd1,  8'd21,  8'd7,  72'h40},                 // R4 ends on last guard tick
    '{1'b0, 4'd1,  8'd21,  8'd8,  72'hC0}                  // R3 one tick past guard
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xing_start = 1'b0;
  logic        legacy_mode = 1'b0;
  logic [47:0] cfg_edges = {8'd148, 8'd120, 8'd94, 8'd70, 8'd46, 8'd22};
  logic [7:0]  cfg_guard = 8'd6;
  logic [11:0] wire_hit = '0;
  logic [71:0] map_out;
  logic        map_valid;

  int checks = 0;
  int errors = 0;
  bit early_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  drift_hit_binner i_drift_hit_binner (
    .clk(clk), .rst(rst), .xing_start(xing_start), .legacy_mode(legacy_mode),
    .cfg_edges(cfg_edges), .cfg_guard(cfg_guard), .wire_hit(wire_hit),
    .map_out(map_out), .map_valid(map_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input bit two);
    @(negedge clk);
    xing_start  = 1'b1;
    legacy_mode = two;
    @(negedge clk);
    xing_start  = 1'b0;
  endtask

  // Drives ticks 0..len_w-1 of an open crossing; optionally strobes on the last one.
  task automatic ticks(input int w, input int s, input int len, input int lw, input bit strobe_last);
    early_valid = 1'b0;
    for (int c = 0; c < lw; c++) begin
      wire_hit = (c >= s && c < s + len) ? (12'd1 << w) : 12'd0;
      if (strobe_last && c == lw - 1) xing_start = 1'b1;
      if (c > 0 && map_valid) early_valid = 1'b1;
      @(negedge clk);
      xing_start = 1'b0;
    end
    wire_hit = '0;
  endtask

  task automatic frame_end(input logic [71:0] exp, input string req);
    chk(!early_valid, "R7 early valid", 72'(early_valid), 72'h0);
    chk(map_valid && map_out == exp, req, map_out, exp);
    @(negedge clk);
    chk(!map_valid, "R7 one-cycle valid", 72'(map_valid), 72'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!map_valid && map_out == '0, "R1 reset", map_out, 72'h0);
    rst = 1'b0;

    // R9: activity with no crossing open
    wire_hit = '1;
    early_valid = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (map_valid) early_valid = 1'b1;
    end
    chk(!early_valid, "R9 no valid while idle", 72'(early_valid), 72'h0);
    wire_hit = '0;
    strobe(1'b0);
    ticks(0, 0, 0, L6, 1'b0);
    frame_end(72'h0, "R9 idle hits discarded");

    // Table of vectors
    for (int v = 0; v < NV; v++) begin
      strobe(VECS[v].two);
      ticks(int'(VECS[v].w), int'(VECS[v].s), int'(VECS[v].len),
            VECS[v].two ? L2 : L6, 1'b0);
      frame_end(VECS[v].exp, $sformatf("R2/R3/R4/R5 vector %0d", v));
    end

    // R6: mode changed right after the strobe
    strobe(1'b1);
    legacy_mode = 1'b0;
    ticks(0, 30, 2, L2, 1'b0);
    frame_end(72'h2, "R6 mode latched at strobe");

    // R8: restart mid-crossing
    strobe(1'b0);
    for (int c = 0; c < 30; c++) begin
      wire_hit = (c < 6) ? 12'h001 : 12'h000;
      @(negedge clk);
    end
    wire_hit = '0;
    xing_start = 1'b1;
    @(negedge clk);
    xing_start = 1'b0;
    ticks(0, 0, 0, L6, 1'b0);
    frame_end(72'h0, "R8 restart discards flags");

    // R10: strobe on the last tick
    strobe(1'b0);
    ticks(0, 2, 3, L6, 1'b1);
    chk(map_valid && map_out == 72'h1, "R10 frame on coincident strobe", map_out, 72'h1);
    ticks(4, 0, 2, L6, 1'b0);
    chk(map_valid && map_out == 72'h1000000, "R10 next crossing started", map_out, 72'h1000000);
    @(negedge clk);
    chk(!map_valid, "R10 one-cycle valid", 72'(map_valid), 72'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 72'h1, 72'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule